// File: doc/BRIEF.md
# Three-Stage Bypassed Register-File ALU

This block is a short integer pipeline wrapped around a small register file. Each clock it takes one instruction: a hold flag, two source register indices, a two-bit operation selector and a destination index. The first stage fetches both operands. The second stage computes the result. The third stage commits that result to the register file. Forwarding paths are placed so that any sequence of instructions leaves the register file exactly as a machine would that retires one instruction per clock with no overlap. The only difference is that each commit appears two clocks after the instruction is accepted.

While the hold flag is high, no instruction enters, and an empty slot moves down the pipe in its place. Two consecutive hold cycles drain every accepted instruction into the register file. An integrator uses this to reach a point where the architectural state can be compared or handed over. The full register file is presented on an output bus so that the committed state can be observed directly. Data width and register count are parameters.

Top module: `rf3_pipe_alu`

## Requirements
- R1: A synchronous active-high reset empties the pipeline and loads register k with the value k, for every k. After reset, the register file shows these values until an accepted instruction commits.
- R2: The operation selector codes are 2'b00 add (src1 + src2), 2'b01 subtract (src1 - src2), 2'b10 bitwise AND and 2'b11 bitwise XOR. All results wrap modulo 2^DATA_W.
- R3: In a cycle where the hold input is high, the instruction fields are ignored and no register changes as a result of that cycle.
- R4: An instruction accepted at clock edge k changes its destination register at edge k+2, and not at edges k or k+1.
- R5: An instruction that reads the destination of the instruction accepted in the previous cycle uses that instruction's new result.
- R6: An instruction that reads the destination of an instruction accepted two cycles earlier uses the new result. This holds whether the cycle between them was a hold or another instruction.
- R7: After any instruction stream followed by two hold cycles, every register equals the value produced by executing the accepted instructions one at a time, in order.
- R8: A commit changes only its destination register. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge active |
| rst_i | input | 1 | Synchronous active-high reset |
| stall_i | input | 1 | Hold: no instruction accepted this cycle |
| src1_i | input | $clog2(NREG) | First operand register index |
| src2_i | input | $clog2(NREG) | Second operand register index |
| op_i | input | 2 | Operation selector |
| dst_i | input | $clog2(NREG) | Destination register index |
| regs_o | output | NREG*DATA_W | Register file contents, register k at bits [k*DATA_W +: DATA_W] |

## Verification
A wrong bypass select or a mis-timed empty-slot flag shows up as a wrong value in one register of `regs_o`. It appears at the commit of the consuming instruction, two edges after that instruction is accepted. It then propagates to every later instruction that reads the corrupted register. Because each random block ends with a two-cycle drain and a full comparison against a sequential model, a fault is reported at the end of the block in which it first occurs. Directed sequences sample the destination at each of the edges k, k+1 and k+2 to pin down latency errors.

// File: rtl/rf3_pkg.sv
package rf3_pkg;

    localparam int OP_W = 2;

    // R2: selector encoding
    typedef enum logic [OP_W-1:0] {
        OP_ADD = 2'b00,
        OP_SUB = 2'b01,
        OP_AND = 2'b10,
        OP_XOR = 2'b11
    } alu_op_e;

    // number of hold cycles needed to drain every accepted instruction
    localparam int DRAIN_CYCLES = 2;

endpackage

// File: rtl/rf3_alu.sv
module rf3_alu
    import rf3_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  alu_op_e           op_i,
    input  logic [DATA_W-1:0] a_i,
    input  logic [DATA_W-1:0] b_i,
    output logic [DATA_W-1:0] y_o
);

    always_comb begin
        unique case (op_i)
            OP_ADD:  y_o = a_i + b_i;
            OP_SUB:  y_o = a_i - b_i;
            OP_AND:  y_o = a_i & b_i;
            OP_XOR:  y_o = a_i ^ b_i;
            default: y_o = '0;
        endcase
    end

endmodule

// File: rtl/rf3_regfile.sv
module rf3_regfile #(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    localparam int AW    = $clog2(NREG)
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   wr_en_i,
    input  logic [AW-1:0]          wr_addr_i,
    input  logic [DATA_W-1:0]      wr_data_i,
    input  logic [AW-1:0]          rd_a_addr_i,
    input  logic [AW-1:0]          rd_b_addr_i,
    output logic [DATA_W-1:0]      rd_a_data_o,
    output logic [DATA_W-1:0]      rd_b_data_o,
    output logic [NREG*DATA_W-1:0] regs_o
);

    logic [DATA_W-1:0] mem [NREG];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int i = 0; i < NREG; i++) begin
                mem[i] <= DATA_W'(i);
            end
        end else if (wr_en_i) begin
            mem[wr_addr_i] <= wr_data_i;
        end
    end

    // Reads see the file as it stands after this cycle's commit.
    always_comb begin
        rd_a_data_o = (wr_en_i && wr_addr_i == rd_a_addr_i) ? wr_data_i : mem[rd_a_addr_i];
        rd_b_data_o = (wr_en_i && wr_addr_i == rd_b_addr_i) ? wr_data_i : mem[rd_b_addr_i];
    end

    for (genvar g = 0; g < NREG; g++) begin : g_flat
        assign regs_o[g*DATA_W +: DATA_W] = mem[g];

        // R8
        only_dest_changes_chk: assert property (@(posedge clk_i) disable iff (rst_i)
            !(wr_en_i && wr_addr_i == AW'(g)) |=> $stable(regs_o[g*DATA_W +: DATA_W]));
    end

    // R3
    no_commit_no_change_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        !wr_en_i |=> $stable(regs_o));

endmodule

// File: rtl/rf3_pipe_alu.sv
module rf3_pipe_alu
    import rf3_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8,
    localparam int AW    = $clog2(NREG)
) (
    input  logic                   clk_i,
    input  logic                   rst_i,
    input  logic                   stall_i,
    input  logic [AW-1:0]          src1_i,
    input  logic [AW-1:0]          src2_i,
    input  logic [1:0]             op_i,
    input  logic [AW-1:0]          dst_i,
    output logic [NREG*DATA_W-1:0] regs_o
);

    typedef struct packed {
        logic              bubble;
        logic [AW-1:0]     dst;
        alu_op_e           op;
        logic [DATA_W-1:0] opa;
        logic [DATA_W-1:0] opb;
    } ex_stage_t;

    typedef struct packed {
        logic              bubble;
        logic [AW-1:0]     dst;
        logic [DATA_W-1:0] res;
    } wb_stage_t;

    ex_stage_t         ex_q;
    wb_stage_t         wb_q;
    logic [DATA_W-1:0] alu_y;
    logic [DATA_W-1:0] rf_a, rf_b;
    logic              fwd_a, fwd_b;

    rf3_alu #(.DATA_W(DATA_W)) u_alu (
        .op_i (ex_q.op),
        .a_i  (ex_q.opa),
        .b_i  (ex_q.opb),
        .y_o  (alu_y)
    );

    rf3_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk_i       (clk_i),
        .rst_i       (rst_i),
        .wr_en_i     (!wb_q.bubble),
        .wr_addr_i   (wb_q.dst),
        .wr_data_i   (wb_q.res),
        .rd_a_addr_i (src1_i),
        .rd_b_addr_i (src2_i),
        .rd_a_data_o (rf_a),
        .rd_b_data_o (rf_b),
        .regs_o      (regs_o)
    );

    // Forward the result being computed now when the execute slot is live.
    always_comb begin
        fwd_a = !ex_q.bubble && (ex_q.dst == src1_i);
        fwd_b = !ex_q.bubble && (ex_q.dst == src2_i);
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ex_q <= '{bubble: 1'b1, dst: '0, op: OP_ADD, opa: '0, opb: '0};
            wb_q <= '{bubble: 1'b1, dst: '0, res: '0};
        end else begin
            ex_q.bubble <= stall_i;
            ex_q.dst    <= dst_i;
            ex_q.op     <= alu_op_e'(op_i);
            ex_q.opa    <= fwd_a ? alu_y : rf_a;
            ex_q.opb    <= fwd_b ? alu_y : rf_b;
            wb_q.bubble <= ex_q.bubble;
            wb_q.dst    <= ex_q.dst;
            wb_q.res    <= alu_y;
        end
    end

    // R1
    reset_empties_pipe_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        $past(rst_i) |-> (ex_q.bubble && wb_q.bubble));

    // R3
    hold_makes_bubble_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        stall_i |=> ex_q.bubble);

    // R4
    bubble_reaches_wb_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (stall_i && !$past(rst_i)) |=> ##1 wb_q.bubble);

endmodule

// File: tb/rf3_pipe_alu_bench.sv
module rf3_pipe_alu_bench;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int NREG       = 8;
    localparam int AW         = $clog2(NREG);

    logic                   clk = 1'b0;
    logic                   rst;
    logic                   stall;
    logic [AW-1:0]          src1, src2, dst;
    logic [1:0]             op;
    logic [NREG*DATA_W-1:0] regs;

    int checks = 0;
    int fails  = 0;
    logic [DATA_W-1:0] model [NREG];

    always #(CLK_PERIOD/2) clk = ~clk;

    rf3_pipe_alu #(.DATA_W(DATA_W), .NREG(NREG)) u_rf3_pipe_alu (
        .clk_i   (clk),
        .rst_i   (rst),
        .stall_i (stall),
        .src1_i  (src1),
        .src2_i  (src2),
        .op_i    (op),
        .dst_i   (dst),
        .regs_o  (regs)
    );

    // R2: expected operation results
    function automatic logic [DATA_W-1:0] ref_alu(input logic [1:0] o,
                                                  input logic [DATA_W-1:0] a,
                                                  input logic [DATA_W-1:0] b);
        case (o)
            2'b00:   return a + b;
            2'b01:   return a - b;
            2'b10:   return a & b;
            default: return a ^ b;
        endcase
    endfunction

    function automatic logic [DATA_W-1:0] reg_at(input int k);
        return regs[k*DATA_W +: DATA_W];
    endfunction

    task automatic check_val(input string tag, input logic [DATA_W-1:0] act,
                             input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic s, input logic [AW-1:0] a, input logic [AW-1:0] b,
                         input logic [1:0] o, input logic [AW-1:0] d);
        stall = s; src1 = a; src2 = b; op = o; dst = d;
        if (!s) model[d] = ref_alu(o, model[a], model[b]);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic hold_random();
        issue(1'b1, AW'($urandom), AW'($urandom), 2'($urandom), AW'($urandom));
    endtask

    task automatic compare_all(input string tag);
        for (int k = 0; k < NREG; k++) check_val(tag, reg_at(k), model[k]);
    endtask

    task automatic drain_and_compare(input string tag);
        hold_random();
        hold_random();
        compare_all(tag);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'h1F3A_5C07));
        rst = 1'b1; stall = 1'b1; src1 = '0; src2 = '0; op = '0; dst = '0;
        for (int k = 0; k < NREG; k++) model[k] = DATA_W'(k);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;

        // R1: reset values
        compare_all("R1 reset value");
        hold_random();
        compare_all("R1 idle after reset");

        // R4: latency of a commit, r0 = r5 - r2 = 3
        issue(1'b0, 3'd5, 3'd2, 2'b01, 3'd0);
        check_val("R4 edge k", reg_at(0), 16'd0);
        hold_random();
        check_val("R4 edge k+1", reg_at(0), 16'd0);
        hold_random();
        check_val("R4 edge k+2", reg_at(0), 16'd3);

        // R5: back-to-back dependency, r1 = r2 + r3, r4 = r1 + r1
        issue(1'b0, 3'd2, 3'd3, 2'b00, 3'd1);
        issue(1'b0, 3'd1, 3'd1, 2'b00, 3'd4);
        drain_and_compare("R5 back-to-back");
        check_val("R5 consumer value", reg_at(4), 16'd10);

        // R6: distance two through another instruction
        issue(1'b0, 3'd6, 3'd7, 2'b11, 3'd2);
        issue(1'b0, 3'd5, 3'd5, 2'b10, 3'd3);
        issue(1'b0, 3'd2, 3'd6, 2'b01, 3'd7);
        drain_and_compare("R6 distance two via instr");

        // R6: distance two through a hold
        issue(1'b0, 3'd4, 3'd7, 2'b00, 3'd5);
        hold_random();
        issue(1'b0, 3'd5, 3'd5, 2'b00, 3'd6);
        drain_and_compare("R6 distance two via hold");

        // R2: each operation with wraparound
        issue(1'b0, 3'd0, 3'd4, 2'b01, 3'd1);
        issue(1'b0, 3'd1, 3'd1, 2'b00, 3'd2);
        issue(1'b0, 3'd2, 3'd6, 2'b10, 3'd3);
        issue(1'b0, 3'd3, 3'd1, 2'b11, 3'd0);
        drain_and_compare("R2 operations");

        // R3: holds with random fields change nothing
        repeat (6) hold_random();
        compare_all("R3 hold ignored");

        // R8: a single commit leaves other registers untouched
        issue(1'b0, 3'd1, 3'd2, 2'b00, 3'd7);
        drain_and_compare("R8 single dest");

        // R7: random streams, drained and compared
        for (int blk = 0; blk < 300; blk++) begin
            int len = 1 + int'($urandom_range(0, 9));
            for (int j = 0; j < len; j++) begin
                issue(($urandom_range(0, 3) == 0), AW'($urandom), AW'($urandom),
                      2'($urandom), AW'($urandom));
            end
            drain_and_compare("R7 random drain");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule